// File: doc/BRIEF.md
# Gated Prescaled Period Timer

A 16-bit up-counter that advances on a chosen count source, divides that source through a selectable prescaler, and returns to zero when it reaches a programmable period value. Each return to zero sets a sticky match flag, and an interrupt output follows that flag when interrupts are enabled. The count source is either the internal instruction tick or an external input. The external input can be taken through a two-flop synchronizer or through a shorter asynchronous capture path, and is counted on its rising edges. In gated mode the same external input acts as a level gate on the internal tick.

Software drives one write port with a 2-bit select. It can load the control word, the counter, the period or the match flag, and it reads the counter back on `cnt_o`. Two system indications, idle and sleep, stop counting under the conditions that the control word and the chosen source define.

Top module: `gated_period_timer`

## Requirements
- R1: After reset the counter reads 0, the match flag and interrupt are 0, every control field is 0, and the period is 0xFFFF.
- R2: A write with `wr_sel_i` = 0 loads the control word, 1 the counter, 2 the period, and 3 the match flag from data bit 0. A counter write takes priority over an increment in the same cycle.
- R3: Control word bits: [0] run, [1] external source, [2] gate enable, [3] synchronize external, [5:4] prescale code, [6] stop in idle, [7] interrupt enable. Writing the control word never changes the counter.
- R4: When a prescaled increment arrives while the counter equals the period, the counter becomes 0 and the match flag sets. Otherwise the increment adds one.
- R5: The match flag stays set until software writes 0 to it. `irq_o` is high exactly when the flag is set and interrupt enable is 1.
- R6: Prescale codes 00, 01, 10 and 11 advance the counter once per 1, 8, 64 and 256 source events.
- R7: With run at 0 the counter does not advance. While run is 1, the prescaler count is cleared by a counter write and by a control write that clears run.
- R8: Gated mode (gate enable 1, internal source) counts internal ticks only while the synchronized external input is high.
- R9: With the external source selected, internal ticks are ignored and only rising edges of the external input count. With synchronize set, the counter changes on the third clock edge after the input rises. With synchronize clear, it changes on the second edge.
- R10: While idle is high and stop-in-idle is 1, counting stops and resumes when idle falls. With stop-in-idle 0, counting continues during idle.
- R11: While sleep is high, counting continues only with the external source selected and synchronize clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Internal instruction tick, one event per high cycle |
| ext_i | input | 1 | External clock/event input, also the gate level |
| idle_i | input | 1 | System idle indication |
| sleep_i | input | 1 | System sleep indication |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 control, 1 counter, 2 period, 3 flag |
| wr_data_i | input | 16 | Write data |
| cnt_o | output | 16 | Counter value |
| match_flag_o | output | 1 | Sticky period-match flag |
| irq_o | output | 1 | Interrupt request, flag gated by enable |

## Verification
The bench runs the counter through the full reset period of 0xFFFF. A design that reset the period to another value would wrap early and leave the flag set at the wrong count. It also stops one tick short of each prescaler boundary, after a counter write and after a disable. A prescaler that kept stale state would then advance the counter one event too soon. It times the external rising edge on both the synchronized and the asynchronous path, so swapped or extra stages show up as a counter that moves a cycle early or late. It also drives a counter write in the same cycle as a tick, and holds the external input high to confirm that a level is not counted as repeated edges.

// File: rtl/gpt_pkg.sv
// Package: shared types and encodings for the gated prescaled period timer.
// Assumes: control word occupies the low bits of the write data bus.
package gpt_pkg;

    // Control word, run at bit 0 up to interrupt enable at bit 7.
    typedef struct packed {
        logic       irq_en;
        logic       idle_stop;
        logic [1:0] psel;
        logic       sync_ext;
        logic       gate_en;
        logic       ext_src;
        logic       run;
    } gpt_ctrl_t;

    localparam int CTRL_W = $bits(gpt_ctrl_t);

    // Write-port targets.
    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_PERIOD = 2'd2,
        SEL_FLAG   = 2'd3
    } gpt_sel_e;

    // Log2 of the division ratio for each prescale code (1, 8, 64, 256).
    function automatic int psel_shift(input logic [1:0] code);
        case (code)
            2'd0:    return 0;
            2'd1:    return 3;
            2'd2:    return 6;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/gpt_input_cond.sv
// Module: conditions the external input.
// Provides a synchronized level (gate), a synchronized rising-edge pulse,
// and a one-flop captured rising-edge pulse for the asynchronous path.
// Assumes: SYNC_STAGES >= 2.
module gpt_input_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_i,
    output logic gate_lvl_o,
    output logic sync_rise_o,
    output logic async_rise_o
);

    logic [SYNC_STAGES:0] sync_q;
    logic                 cap_q;
    logic                 cap_prev_q;

    // Synchronizer chain plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-1:0], ext_i};
    end

    // Short capture path used when synchronization is switched off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q      <= 1'b0;
            cap_prev_q <= 1'b0;
        end else begin
            cap_q      <= ext_i;
            cap_prev_q <= cap_q;
        end
    end

    // Level and edge outputs.
    always_comb begin
        gate_lvl_o   = sync_q[SYNC_STAGES-1];
        sync_rise_o  = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
        async_rise_o = cap_q & ~cap_prev_q;
    end

endmodule

// File: rtl/gpt_prescaler.sv
// Module: event divider with ratios 1, 8, 64 or 256.
// Emits one output pulse per N input events; clr_i zeroes the divider.
// Assumes: PRE_W >= 8 so the largest ratio fits.
module gpt_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_i,
    input  logic       clr_i,
    input  logic [1:0] psel_i,
    output logic       tick_o
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] term;

    // Terminal count for the selected ratio.
    always_comb begin
        term   = PRE_W'((32'd1 << gpt_pkg::psel_shift(psel_i)) - 32'd1);
        tick_o = evt_i & (pre_q == term);
    end

    // Divider count: clears first, then advances on events.
    always_ff @(posedge clk) begin
        if (!rst_n)      pre_q <= '0;
        else if (clr_i)  pre_q <= '0;
        else if (evt_i)  pre_q <= (pre_q == term) ? '0 : pre_q + PRE_W'(1);
    end

endmodule

// File: rtl/gpt_counter.sv
// Module: counter, period register and sticky match flag.
// Counter write wins over increment; hardware flag set wins over software write.
// Assumes: inc_i is a single-cycle pulse per prescaled event.
module gpt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             cnt_wr_i,
    input  logic             per_wr_i,
    input  logic             flag_wr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] period_o,
    output logic             flag_o
);

    logic hit;

    // Increment that lands on the period value.
    always_comb hit = inc_i & ~cnt_wr_i & (cnt_o == period_o);

    // Counter: load, wrap at period, or step.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_o <= '0;
        else if (cnt_wr_i) cnt_o <= wr_data_i;
        else if (hit)      cnt_o <= '0;
        else if (inc_i)    cnt_o <= cnt_o + CNT_W'(1);
    end

    // Period register, all ones after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        period_o <= '1;
        else if (per_wr_i) period_o <= wr_data_i;
    end

    // Sticky match flag.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_o <= 1'b0;
        else if (hit)       flag_o <= 1'b1;
        else if (flag_wr_i) flag_o <= wr_data_i[0];
    end

endmodule

// File: rtl/gated_period_timer.sv
// Module: top of the gated prescaled period timer.
// Holds the control word, decodes writes, picks the count source, applies
// idle/sleep run conditions and feeds prescaler and counter.
// Assumes: CNT_W >= control word width; one write per cycle.
module gated_period_timer #(
    parameter int CNT_W       = 16,
    parameter int PRE_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             ext_i,
    input  logic             idle_i,
    input  logic             sleep_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             match_flag_o,
    output logic             irq_o
);
    import gpt_pkg::*;

    gpt_ctrl_t        ctrl_q;
    logic             ctrl_wr, cnt_wr, per_wr, flag_wr;
    logic             gate_lvl, sync_rise, async_rise;
    logic             run_ok, src_evt, pre_evt, pre_clr, pre_tick;
    logic [CNT_W-1:0] period;

    // Write decode.
    always_comb begin
        ctrl_wr = wr_en_i && (wr_sel_i == SEL_CTRL);
        cnt_wr  = wr_en_i && (wr_sel_i == SEL_COUNT);
        per_wr  = wr_en_i && (wr_sel_i == SEL_PERIOD);
        flag_wr = wr_en_i && (wr_sel_i == SEL_FLAG);
    end

    // Control register; counter is untouched by this write.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= gpt_ctrl_t'(wr_data_i[CTRL_W-1:0]);
    end

    gpt_input_cond #(.SYNC_STAGES(SYNC_STAGES)) u_inp (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_i        (ext_i),
        .gate_lvl_o   (gate_lvl),
        .sync_rise_o  (sync_rise),
        .async_rise_o (async_rise)
    );

    // Run conditions, source select and prescaler clear rules.
    always_comb begin
        run_ok = ctrl_q.run
               & ~(idle_i & ctrl_q.idle_stop)
               & (~sleep_i | (ctrl_q.ext_src & ~ctrl_q.sync_ext));
        if (ctrl_q.ext_src)
            src_evt = ctrl_q.sync_ext ? sync_rise : async_rise;
        else
            src_evt = tick_i & (~ctrl_q.gate_en | gate_lvl);
        pre_evt = run_ok & src_evt;
        pre_clr = ctrl_q.run & (cnt_wr | (ctrl_wr & ~wr_data_i[0]));
    end

    gpt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (pre_evt),
        .clr_i  (pre_clr),
        .psel_i (ctrl_q.psel),
        .tick_o (pre_tick)
    );

    gpt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_i     (pre_tick),
        .cnt_wr_i  (cnt_wr),
        .per_wr_i  (per_wr),
        .flag_wr_i (flag_wr),
        .wr_data_i (wr_data_i),
        .cnt_o     (cnt_o),
        .period_o  (period),
        .flag_o    (match_flag_o)
    );

    // Interrupt follows the flag when enabled.
    always_comb irq_o = match_flag_o & ctrl_q.irq_en;

endmodule

// File: rtl/gpt_checker.sv
// Module: property checker for gated_period_timer, attached by bind.
// Assumes: inc_i is the prescaled increment pulse inside the top.
module gpt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en_i,
    input logic [1:0]       wr_sel_i,
    input logic [CNT_W-1:0] wr_data_i,
    input logic             idle_i,
    input logic             sleep_i,
    input logic [CNT_W-1:0] cnt_o,
    input logic             match_flag_o,
    input logic             irq_o,
    input logic             inc_i,
    input logic [CNT_W-1:0] period_i,
    input logic             run_i,
    input logic             ext_src_i,
    input logic             sync_ext_i,
    input logic             idle_stop_i,
    input logic             irq_en_i
);

    logic cw;
    always_comb cw = wr_en_i && (wr_sel_i == 2'd1);

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cw |=> (cnt_o == $past(wr_data_i)));                                   // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !cw && cnt_o != period_i) |=> (cnt_o == $past(cnt_o) + CNT_W'(1))); // R4
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !cw && cnt_o == period_i) |=> (cnt_o == '0 && match_flag_o));  // R4
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !cw) |=> $stable(cnt_o));                                   // R3
    AST_OFF_NO_INC: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> !inc_i);                                                    // R7
    AST_IDLE_NO_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_i && idle_stop_i) |-> !inc_i);                                   // R10
    AST_SLEEP_NO_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && !(ext_src_i && !sync_ext_i)) |-> !inc_i);                  // R11
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |-> !irq_o);                                                 // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag_o && !(wr_en_i && wr_sel_i == 2'd3)) |=> match_flag_o);    // R5

endmodule

bind gated_period_timer gpt_checker #(.CNT_W(CNT_W)) u_gpt_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (wr_en_i),
    .wr_sel_i     (wr_sel_i),
    .wr_data_i    (wr_data_i),
    .idle_i       (idle_i),
    .sleep_i      (sleep_i),
    .cnt_o        (cnt_o),
    .match_flag_o (match_flag_o),
    .irq_o        (irq_o),
    .inc_i        (pre_tick),
    .period_i     (period),
    .run_i        (ctrl_q.run),
    .ext_src_i    (ctrl_q.ext_src),
    .sync_ext_i   (ctrl_q.sync_ext),
    .idle_stop_i  (ctrl_q.idle_stop),
    .irq_en_i     (ctrl_q.irq_en)
);

// File: tb/test_gated_period_timer.sv
// Bench: scoreboard. Driver tasks push expected output items; a monitor pops
// and compares them against the ports one ns after the pushing negedge.
module test_gated_period_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0, ext_i = 1'b0, idle_i = 1'b0, sleep_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_sel_i = 2'd0;
    logic [15:0] wr_data_i = 16'd0;
    logic [15:0] cnt_o;
    logic        match_flag_o, irq_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [15:0] cnt;
        logic        flag;
        logic        irq;
        logic        full;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    event  pushed;

    always #5 clk = ~clk;

    gated_period_timer i_gated_period_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ext_i(ext_i),
        .idle_i(idle_i), .sleep_i(sleep_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .cnt_o(cnt_o),
        .match_flag_o(match_flag_o), .irq_o(irq_o)
    );

    task automatic push(input logic [15:0] c, input logic f, input logic i,
                        input logic full, input string tag);
        exp_q.push_back({c, f, i, full});
        tag_q.push_back(tag);
        -> pushed;
    endtask

    task automatic chk_cnt(input logic [15:0] c, input string tag);
        push(c, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic chk_all(input logic [15:0] c, input logic f, input logic i,
                           input string tag);
        push(c, f, i, 1'b1, tag);
    endtask

    // Monitor: compare every queued item against the outputs.
    initial begin
        forever begin
            @(pushed);
            #1;
            while (exp_q.size() != 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (cnt_o !== e.cnt ||
                    (e.full && (match_flag_o !== e.flag || irq_o !== e.irq))) begin
                    bad++;
                    $display("FAIL %s: got cnt=%h flag=%b irq=%b exp cnt=%h flag=%b irq=%b",
                             t, cnt_o, match_flag_o, irq_o, e.cnt, e.flag, e.irq);
                end
            end
        end
    end

    task automatic do_write(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(1);
        chk_all(16'h0000, 1'b0, 1'b0, "R1 reset state");

        // R1: default period 0xFFFF
        do_write(2'd0, 16'h0001);
        ticks(65535);
        chk_all(16'hFFFF, 1'b0, 1'b0, "R1 counts up to reset period");
        ticks(1);
        chk_all(16'h0000, 1'b1, 1'b0, "R1 wrap at reset period");
        do_write(2'd3, 16'h0000);
        chk_all(16'h0000, 1'b0, 1'b0, "R5 flag cleared by write");

        // R4 period compare, R5 sticky flag / irq, R3 control write
        do_write(2'd2, 16'd3);
        ticks(3);
        chk_all(16'd3, 1'b0, 1'b0, "R4 count to period");
        ticks(1);
        chk_all(16'd0, 1'b1, 1'b0, "R4 wrap at period");
        ticks(2);
        chk_all(16'd2, 1'b1, 1'b0, "R5 flag sticky");
        do_write(2'd0, 16'h0081);
        chk_all(16'd2, 1'b1, 1'b1, "R3 control write keeps count, R5 irq");
        do_write(2'd3, 16'h0000);
        chk_all(16'd2, 1'b0, 1'b0, "R5 clear drops irq");

        // R6 prescaler ratios
        do_write(2'd2, 16'd1000);
        do_write(2'd0, 16'h0011);
        do_write(2'd1, 16'd0);
        ticks(7);
        chk_cnt(16'd0, "R6 div8 holds before 8th");
        ticks(1);
        chk_cnt(16'd1, "R6 div8 step");

        // R7 prescaler clear rules
        ticks(5);
        do_write(2'd1, 16'd10);
        ticks(7);
        chk_cnt(16'd10, "R7 count write clears prescaler");
        ticks(1);
        chk_cnt(16'd11, "R7 step after count write");
        ticks(5);
        do_write(2'd0, 16'h0010);
        ticks(3);
        chk_cnt(16'd11, "R7 no count when disabled");
        do_write(2'd0, 16'h0011);
        ticks(7);
        chk_cnt(16'd11, "R7 disable clears prescaler");
        ticks(1);
        chk_cnt(16'd12, "R7 step after re-enable");

        do_write(2'd0, 16'h0021);
        do_write(2'd1, 16'd0);
        ticks(63);
        chk_cnt(16'd0, "R6 div64 holds");
        ticks(1);
        chk_cnt(16'd1, "R6 div64 step");
        do_write(2'd0, 16'h0031);
        do_write(2'd1, 16'd0);
        ticks(255);
        chk_cnt(16'd0, "R6 div256 holds");
        ticks(1);
        chk_cnt(16'd1, "R6 div256 step");

        // R8 gated accumulation
        do_write(2'd0, 16'h0005);
        do_write(2'd1, 16'd0);
        ticks(5);
        chk_cnt(16'd0, "R8 gate low blocks ticks");
        ext_i = 1'b1;
        wait_neg(3);
        ticks(4);
        chk_cnt(16'd4, "R8 gate high passes ticks");
        ext_i = 1'b0;
        wait_neg(3);
        ticks(3);
        chk_cnt(16'd4, "R8 gate low again blocks");

        // R9 external source, synchronized and asynchronous
        do_write(2'd0, 16'h000B);
        do_write(2'd1, 16'd0);
        ticks(5);
        chk_cnt(16'd0, "R9 internal tick ignored on external source");
        @(negedge clk); ext_i = 1'b1;
        wait_neg(2);
        chk_cnt(16'd0, "R9 sync path not yet at second edge");
        wait_neg(1);
        chk_cnt(16'd1, "R9 sync path counts at third edge");
        wait_neg(3);
        chk_cnt(16'd1, "R9 held level counts once");
        ext_i = 1'b0;
        wait_neg(4);
        chk_cnt(16'd1, "R9 falling edge not counted");
        do_write(2'd0, 16'h0003);
        do_write(2'd1, 16'd0);
        @(negedge clk); ext_i = 1'b1;
        wait_neg(1);
        chk_cnt(16'd0, "R9 async path not yet at first edge");
        wait_neg(1);
        chk_cnt(16'd1, "R9 async path counts at second edge");
        ext_i = 1'b0;
        wait_neg(3);

        // R10 idle handling
        do_write(2'd0, 16'h0041);
        do_write(2'd1, 16'd0);
        idle_i = 1'b1;
        ticks(3);
        chk_cnt(16'd0, "R10 stop in idle");
        idle_i = 1'b0;
        ticks(2);
        chk_cnt(16'd2, "R10 resume after idle");
        do_write(2'd0, 16'h0001);
        idle_i = 1'b1;
        ticks(3);
        chk_cnt(16'd5, "R10 counts in idle when stop bit clear");
        idle_i = 1'b0;

        // R11 sleep handling
        sleep_i = 1'b1;
        ticks(3);
        chk_cnt(16'd5, "R11 internal source stops in sleep");
        do_write(2'd0, 16'h000B);
        ext_i = 1'b1; wait_neg(4);
        ext_i = 1'b0; wait_neg(3);
        chk_cnt(16'd5, "R11 synchronized external stops in sleep");
        do_write(2'd0, 16'h0003);
        ext_i = 1'b1; wait_neg(3);
        ext_i = 1'b0; wait_neg(3);
        chk_cnt(16'd6, "R11 asynchronous external counts in sleep");
        sleep_i = 1'b0;

        // R2 write priority and flag write
        do_write(2'd0, 16'h0001);
        @(negedge clk);
        tick_i = 1'b1; wr_en_i = 1'b1; wr_sel_i = 2'd1; wr_data_i = 16'h0050;
        @(negedge clk);
        tick_i = 1'b0; wr_en_i = 1'b0;
        chk_cnt(16'h0050, "R2 counter write beats increment");
        ticks(1);
        chk_cnt(16'h0051, "R2 counting resumes after write");
        do_write(2'd3, 16'h0001);
        chk_all(16'h0051, 1'b1, 1'b0, "R2 flag write sets flag");

        wait_neg(2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule